// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block decides when an asynchronous fast-page-mode DRAM receives refresh cycles and shares the memory's access sequencer between those cycles and host traffic. It sits beside the sequencer that drives the strobe pins. It never drives a pin itself. It issues one-cycle commands: start a CAS-before-RAS refresh, grant the pending host access, or start a CBR cycle that holds RAS low for self refresh. A command is issued only in a cycle where the sequencer reports idle, meaning RAS has been high for its precharge time.

After reset the block waits out the power-up pause. It then issues a fixed number of wake-up refresh cycles before it grants any host access. In normal running an interval timer paces distributed refresh at one row per interval. The interval is chosen by the row-count option (2k or 4k rows) and by the standard or extended (128 ms) retention period. Intervals that could not be served are counted in a small backlog. If the backlog overflows, the retention rule counts as broken: a sticky error is raised and the wake-up cycles are issued again.

Self refresh is requested by a level input. The hold lasts at least the minimum self-refresh time, and on exit the block waits a recovery time before it issues any command. If the controller does not run distributed refresh, a catch-up burst that covers every row then follows before host access resumes.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is asserted (rst_n sampled low), every command output, sr_hold, init_done and ovf_err are 0.
- R2: After reset is released, no command is issued for PAUSE_CYC clock cycles, and the first wake-up refresh appears exactly PAUSE_CYC cycles after release when the sequencer is idle.
- R3: Exactly WAKE_CNT refresh commands are issued after the pause, then init_done goes to 1. cmd_host is never 1 while init_done is 0.
- R4: While running with no backlog and an idle sequencer, consecutive refresh commands are spaced by the selected interval: INT_STD_2K (row_4k=0, ext_period=0), INT_STD_4K (row_4k=1, ext_period=0), INT_EXT_2K (row_4k=0, ext_period=1) or INT_EXT_4K (row_4k=1, ext_period=1).
- R5: Pending refresh takes priority over self-refresh entry, and self-refresh entry takes priority over a host request. cmd_host is issued only when no refresh is pending.
- R6: At most one of cmd_ref, cmd_host and cmd_sr is 1 in any cycle, and a command is issued only while seq_idle is 1.
- R7: When an interval elapses while BACKLOG_MAX refreshes are already pending, ovf_err becomes 1 and stays 1 until reset, init_done drops to 0, and WAKE_CNT refresh commands are issued again before init_done returns to 1.
- R8: cmd_sr starts self refresh. sr_hold is then 1 for at least RASS_CYC cycles, and exactly RASS_CYC cycles when sr_req is already low at that point. No command is issued while sr_hold is 1.
- R9: After sr_hold falls, no command is issued for RPS_CYC cycles. A pending host request is granted exactly RPS_CYC cycles after the fall.
- R10: On self-refresh exit with dist_mode=1, no catch-up refresh is issued. With dist_mode=0, ROWS_2K (row_4k=0) or ROWS_4K (row_4k=1) refresh commands are issued before any host grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| row_4k | input | 1 | 1 selects the 4k-row option, 0 the 2k-row option |
| ext_period | input | 1 | 1 selects the extended 128 ms retention pacing |
| dist_mode | input | 1 | 1 = controller uses distributed refresh (no burst on self-refresh exit) |
| seq_idle | input | 1 | Access sequencer idle, RAS high for at least its precharge time |
| host_req | input | 1 | A host access is queued at the sequencer |
| sr_req | input | 1 | Level request to enter and stay in self refresh |
| cmd_ref | output | 1 | One-cycle command: run one CBR refresh cycle |
| cmd_host | output | 1 | One-cycle grant: run the queued host access |
| cmd_sr | output | 1 | One-cycle command: start a CBR cycle and keep RAS low |
| sr_hold | output | 1 | Keep RAS low (self refresh in progress) |
| init_done | output | 1 | Wake-up sequence complete, host access allowed |
| ovf_err | output | 1 | Sticky: refresh backlog overflowed |

## Verification
The assertions check the per-cycle rules on every cycle: the three commands are mutually exclusive and issued only while the sequencer is idle, no host grant comes before init_done or while refresh is pending, the self-refresh hold and recovery windows are at least their minimum lengths, and the error flag is sticky. Some properties need whole scenarios and are shown only by the bench. These are the exact pause length, the count of wake-up and catch-up refreshes, the refresh spacing in each of the four pacing settings, the command order when refresh and host requests compete, and the re-run of the wake-up sequence after a backlog overflow.

// File: rtl/dram_rs_pkg.sv
// Shared types for the DRAM refresh scheduler.
package dram_rs_pkg;
    // Phases of the scheduler's control sequence.
    typedef enum logic [2:0] {
        ST_PAUSE   = 3'd0,
        ST_WAKE    = 3'd1,
        ST_RUN     = 3'd2,
        ST_SR_HOLD = 3'd3,
        ST_SR_REC  = 3'd4,
        ST_CATCH   = 3'd5
    } rs_state_e;

    // Larger of two integers, for sizing counters.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/rs_interval_timer.sv
// Interval timer: produces a one-cycle tick each time one row's refresh
// interval has elapsed. The interval is picked from four parameters by
// the row option and the retention-period option.
// Assumes: run is low outside normal running, which restarts the interval.
module rs_interval_timer #(
    parameter int INT_STD_2K = 1562,
    parameter int INT_STD_4K = 1562,
    parameter int INT_EXT_2K = 6250,
    parameter int INT_EXT_4K = 3125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic row_4k,
    input  logic ext_period,
    output logic tick
);
    import dram_rs_pkg::*;

    localparam int MAXI = imax(imax(INT_STD_2K, INT_STD_4K), imax(INT_EXT_2K, INT_EXT_4K));
    localparam int TW   = $clog2(MAXI + 1);

    logic [TW-1:0] cnt;
    logic [TW-1:0] last;

    // Pick the final count of the selected interval.
    always_comb begin
        case ({ext_period, row_4k})
            2'b00:   last = TW'(INT_STD_2K - 1);
            2'b01:   last = TW'(INT_STD_4K - 1);
            2'b10:   last = TW'(INT_EXT_2K - 1);
            default: last = TW'(INT_EXT_4K - 1);
        endcase
    end

    // Tick on reaching the end; >= covers an option change mid-interval.
    assign tick = run && (cnt >= last);

    // Advance the interval counter, restarting on tick or when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) cnt <= '0;
        else                        cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/rs_backlog.sv
// Refresh backlog counter: counts intervals not yet served by a refresh.
// Flags an overflow when an interval elapses with the count already full.
// Assumes: clear has priority and is held outside normal running.
module rs_backlog #(
    parameter int BACKLOG_MAX = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic inc,
    input  logic dec,
    output logic pend_nz,
    output logic ovf
);
    localparam int BW = $clog2(BACKLOG_MAX + 1);
    localparam logic [BW-1:0] FULL = BW'(BACKLOG_MAX);

    logic [BW-1:0] cnt;

    assign pend_nz = (cnt != '0);
    assign ovf     = !clear && inc && !dec && (cnt == FULL);

    // Track pending refreshes: add on tick, remove on a served refresh.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)               cnt <= '0;
        else if (inc && !dec && !ovf)      cnt <= cnt + 1'b1;
        else if (dec && !inc && cnt != '0) cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/rs_ctrl.sv
// Control sequencer for the refresh scheduler: power-up pause, wake-up
// refreshes, normal arbitration (refresh > self refresh > host), self-
// refresh hold and recovery, and the catch-up burst on exit.
// Assumes: the access sequencer drops seq_idle within one cycle of any
// command; a command is never issued in two consecutive cycles.
module rs_ctrl #(
    parameter int PAUSE_CYC = 10000,
    parameter int WAKE_CNT  = 8,
    parameter int RASS_CYC  = 10000,
    parameter int RPS_CYC   = 11,
    parameter int ROWS_2K   = 2048,
    parameter int ROWS_4K   = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic seq_idle,
    input  logic host_req,
    input  logic sr_req,
    input  logic dist_mode,
    input  logic row_4k,
    input  logic pend_nz,
    input  logic ovf,
    output logic cmd_ref,
    output logic cmd_host,
    output logic cmd_sr,
    output logic sr_hold,
    output logic init_done,
    output logic ovf_err,
    output logic run_en,
    output logic bl_clear,
    output logic bl_dec
);
    import dram_rs_pkg::*;

    localparam int MAXC = imax(imax(PAUSE_CYC, RASS_CYC), imax(imax(RPS_CYC, WAKE_CNT), imax(ROWS_2K, ROWS_4K)));
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] PAUSE_LAST = CW'(PAUSE_CYC - 1);
    localparam logic [CW-1:0] WAKE_LAST  = CW'(WAKE_CNT - 1);
    localparam logic [CW-1:0] RASS_LAST  = CW'(RASS_CYC - 1);
    localparam logic [CW-1:0] RPS_LAST   = CW'(RPS_CYC - 1);
    localparam logic [CW-1:0] R2K_LAST   = CW'(ROWS_2K - 1);
    localparam logic [CW-1:0] R4K_LAST   = CW'(ROWS_4K - 1);

    rs_state_e     state, nxt;
    logic [CW-1:0] cnt;
    logic          issued_q;
    logic          can_issue;
    logic [CW-1:0] rows_last;

    assign can_issue = seq_idle && !issued_q;
    assign rows_last = row_4k ? R4K_LAST : R2K_LAST;

    // Next phase and the command issued in this cycle.
    always_comb begin
        nxt      = state;
        cmd_ref  = 1'b0;
        cmd_host = 1'b0;
        cmd_sr   = 1'b0;
        case (state)
            ST_PAUSE: begin
                if (cnt == PAUSE_LAST) nxt = ST_WAKE;
            end
            ST_WAKE: begin
                if (can_issue) begin
                    cmd_ref = 1'b1;
                    if (cnt == WAKE_LAST) nxt = ST_RUN;
                end
            end
            ST_RUN: begin
                if (can_issue) begin
                    if (pend_nz) cmd_ref = 1'b1;
                    else if (sr_req) begin
                        cmd_sr = 1'b1;
                        nxt    = ST_SR_HOLD;
                    end else if (host_req) cmd_host = 1'b1;
                end
                if (ovf) nxt = ST_WAKE;
            end
            ST_SR_HOLD: begin
                if (cnt >= RASS_LAST && !sr_req) nxt = ST_SR_REC;
            end
            ST_SR_REC: begin
                if (cnt == RPS_LAST) nxt = dist_mode ? ST_RUN : ST_CATCH;
            end
            ST_CATCH: begin
                if (can_issue) begin
                    cmd_ref = 1'b1;
                    if (cnt == rows_last) nxt = ST_RUN;
                end
            end
            default: nxt = ST_PAUSE;
        endcase
    end

    // Phase register and its shared cycle/command counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_PAUSE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (nxt != state) cnt <= '0;
            else begin
                case (state)
                    ST_PAUSE, ST_SR_REC: cnt <= cnt + 1'b1;
                    ST_SR_HOLD:          if (cnt < RASS_LAST) cnt <= cnt + 1'b1;
                    ST_WAKE, ST_CATCH:   if (cmd_ref) cnt <= cnt + 1'b1;
                    default:             cnt <= '0;
                endcase
            end
        end
    end

    // Remember a command in the previous cycle to keep commands apart.
    always_ff @(posedge clk) begin
        if (!rst_n) issued_q <= 1'b0;
        else        issued_q <= cmd_ref || cmd_host || cmd_sr;
    end

    // Sticky overflow flag, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)   ovf_err <= 1'b0;
        else if (ovf) ovf_err <= 1'b1;
    end

    assign sr_hold   = (state == ST_SR_HOLD);
    assign init_done = (state != ST_PAUSE) && (state != ST_WAKE);
    assign run_en    = (state == ST_RUN);
    assign bl_clear  = (state != ST_RUN);
    assign bl_dec    = cmd_ref && (state == ST_RUN);
endmodule

// File: rtl/dram_refresh_sched.sv
// DRAM refresh scheduler top: ties the interval timer, the backlog counter
// and the control sequencer together. All times are in clock cycles.
// Assumes: the access sequencer turns each command into pin activity and
// reports idle only when RAS has been high for its precharge time.
module dram_refresh_sched #(
    parameter int PAUSE_CYC   = 10000,
    parameter int WAKE_CNT    = 8,
    parameter int INT_STD_2K  = 1562,
    parameter int INT_STD_4K  = 1562,
    parameter int INT_EXT_2K  = 6250,
    parameter int INT_EXT_4K  = 3125,
    parameter int RASS_CYC    = 10000,
    parameter int RPS_CYC     = 11,
    parameter int ROWS_2K     = 2048,
    parameter int ROWS_4K     = 4096,
    parameter int BACKLOG_MAX = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic row_4k,
    input  logic ext_period,
    input  logic dist_mode,
    input  logic seq_idle,
    input  logic host_req,
    input  logic sr_req,
    output logic cmd_ref,
    output logic cmd_host,
    output logic cmd_sr,
    output logic sr_hold,
    output logic init_done,
    output logic ovf_err
);
    logic tick, run_en, bl_clear, bl_dec, pend_nz, ovf;

    rs_interval_timer #(
        .INT_STD_2K(INT_STD_2K), .INT_STD_4K(INT_STD_4K),
        .INT_EXT_2K(INT_EXT_2K), .INT_EXT_4K(INT_EXT_4K)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .run(run_en),
        .row_4k(row_4k), .ext_period(ext_period), .tick(tick)
    );

    rs_backlog #(.BACKLOG_MAX(BACKLOG_MAX)) u_backlog (
        .clk(clk), .rst_n(rst_n), .clear(bl_clear), .inc(tick),
        .dec(bl_dec), .pend_nz(pend_nz), .ovf(ovf)
    );

    rs_ctrl #(
        .PAUSE_CYC(PAUSE_CYC), .WAKE_CNT(WAKE_CNT), .RASS_CYC(RASS_CYC),
        .RPS_CYC(RPS_CYC), .ROWS_2K(ROWS_2K), .ROWS_4K(ROWS_4K)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .seq_idle(seq_idle), .host_req(host_req),
        .sr_req(sr_req), .dist_mode(dist_mode), .row_4k(row_4k),
        .pend_nz(pend_nz), .ovf(ovf), .cmd_ref(cmd_ref), .cmd_host(cmd_host),
        .cmd_sr(cmd_sr), .sr_hold(sr_hold), .init_done(init_done),
        .ovf_err(ovf_err), .run_en(run_en), .bl_clear(bl_clear), .bl_dec(bl_dec)
    );
endmodule

// File: rtl/dram_refresh_sched_chk.sv
// Checker for the refresh scheduler: per-cycle command and timing rules.
// Counters measure the self-refresh hold and recovery windows.
module dram_refresh_sched_chk #(
    parameter int RASS_CYC = 10000,
    parameter int RPS_CYC  = 11
) (
    input logic clk,
    input logic rst_n,
    input logic seq_idle,
    input logic cmd_ref,
    input logic cmd_host,
    input logic cmd_sr,
    input logic sr_hold,
    input logic init_done,
    input logic ovf_err,
    input logic pend_nz
);
    logic [31:0] hold_len;
    logic [31:0] rec_len;
    logic        any_cmd;

    assign any_cmd = cmd_ref || cmd_host || cmd_sr;

    // Count cycles spent holding and recovering from self refresh.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_len <= '0;
            rec_len  <= 32'(RPS_CYC);
        end else if (sr_hold) begin
            hold_len <= hold_len + 1;
            rec_len  <= '0;
        end else begin
            hold_len <= '0;
            if (rec_len < 32'(RPS_CYC)) rec_len <= rec_len + 1;
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> (!init_done && !ovf_err && !sr_hold) || rst_n);
    // R6
    one_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({cmd_ref, cmd_host, cmd_sr}));
    // R6
    cmd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) any_cmd |-> seq_idle);
    // R3
    host_after_init_chk: assert property (@(posedge clk) disable iff (!rst_n) cmd_host |-> init_done);
    // R5
    host_no_pend_chk: assert property (@(posedge clk) disable iff (!rst_n) cmd_host |-> !pend_nz);
    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) ovf_err |=> ovf_err);
    // R8
    hold_min_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(sr_hold) |-> hold_len >= 32'(RASS_CYC));
    // R8
    hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) sr_hold |-> !any_cmd);
    // R9
    recovery_chk: assert property (@(posedge clk) disable iff (!rst_n) any_cmd |-> rec_len >= 32'(RPS_CYC));
endmodule

bind dram_refresh_sched dram_refresh_sched_chk #(.RASS_CYC(RASS_CYC), .RPS_CYC(RPS_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .seq_idle(seq_idle), .cmd_ref(cmd_ref),
    .cmd_host(cmd_host), .cmd_sr(cmd_sr), .sr_hold(sr_hold),
    .init_done(init_done), .ovf_err(ovf_err), .pend_nz(pend_nz)
);

// File: tb/dram_refresh_sched_bench.sv
// Scoreboard bench: tasks queue the expected command order and a monitor
// compares each issued command; a small model plays the access sequencer.
module dram_refresh_sched_bench;
    localparam int PAUSE = 50, WAKE = 8, P2 = 40, P4 = 30, E2 = 80, E4 = 60;
    localparam int RASS = 40, RPS = 5, ROWS2 = 16, ROWS4 = 24, BLMAX = 8;
    localparam int C_REF = 1, C_HOST = 2, C_SR = 3;

    logic clk = 0, rst_n = 0;
    logic row_4k = 0, ext_period = 0, dist_mode = 1, host_req = 0, sr_req = 0;
    logic force_busy = 0;
    logic seq_idle, cmd_ref, cmd_host, cmd_sr, sr_hold, init_done, ovf_err;
    int   busy;
    int   total = 0, fails = 0;
    int   exp_q[$];
    bit   sb_on = 0;

    always #5 clk = ~clk;

    dram_refresh_sched #(
        .PAUSE_CYC(PAUSE), .WAKE_CNT(WAKE), .INT_STD_2K(P2), .INT_STD_4K(P4),
        .INT_EXT_2K(E2), .INT_EXT_4K(E4), .RASS_CYC(RASS), .RPS_CYC(RPS),
        .ROWS_2K(ROWS2), .ROWS_4K(ROWS4), .BACKLOG_MAX(BLMAX)
    ) u_dram_refresh_sched (
        .clk(clk), .rst_n(rst_n), .row_4k(row_4k), .ext_period(ext_period),
        .dist_mode(dist_mode), .seq_idle(seq_idle), .host_req(host_req),
        .sr_req(sr_req), .cmd_ref(cmd_ref), .cmd_host(cmd_host), .cmd_sr(cmd_sr),
        .sr_hold(sr_hold), .init_done(init_done), .ovf_err(ovf_err)
    );

    // Sequencer model: busy for 3 cycles after any command, busy in self refresh.
    always @(posedge clk) begin
        if (!rst_n) busy <= 0;
        else if (cmd_ref || cmd_host || cmd_sr) busy <= 3;
        else if (busy != 0) busy <= busy - 1;
    end
    assign seq_idle = rst_n && (busy == 0) && !sr_hold && !force_busy;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Monitor: compare each issued command with the scoreboard queue.
    always @(negedge clk) begin
        if (rst_n && (cmd_ref || cmd_host || cmd_sr)) begin
            int code;
            code = cmd_ref ? C_REF : (cmd_host ? C_HOST : C_SR);
            if (cmd_host) host_req = 0;
            if (sb_on) begin
                if (exp_q.size() == 0) chk(0, "R5/R10", "unexpected command", code, 0);
                else begin
                    int e;
                    e = exp_q.pop_front();
                    chk(code == e, "R3/R5/R7/R10", "command order", code, e);
                end
            end
        end
    end

    task automatic push(input int code, input int n);
        for (int i = 0; i < n; i++) exp_q.push_back(code);
    endtask

    task automatic wait_empty(input string req, input int limit);
        int n;
        n = 0;
        while (exp_q.size() != 0 && n < limit) begin
            @(negedge clk);
            n++;
        end
        chk(exp_q.size() == 0, req, "expected commands left", exp_q.size(), 0);
    endtask

    task automatic wait_ref();
        do @(negedge clk); while (!cmd_ref);
    endtask

    task automatic gap_check(input bit r4, input bit ex, input int expv, input string req);
        int t;
        row_4k = r4;
        ext_period = ex;
        wait_ref();
        wait_ref();
        t = 0;
        do begin
            @(negedge clk);
            t++;
        end while (!cmd_ref);
        chk(t == expv, req, "refresh spacing", t, expv);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        int n;
        repeat (5) @(negedge clk);
        // R1: reset values
        chk({cmd_ref, cmd_host, cmd_sr, sr_hold, init_done, ovf_err} == 6'b0, "R1", "outputs in reset",
            {cmd_ref, cmd_host, cmd_sr, sr_hold, init_done, ovf_err}, 0);

        // R2/R3: pause, eight wake-up refreshes, then the host grant
        host_req = 1;
        push(C_REF, WAKE);
        push(C_HOST, 1);
        sb_on = 1;
        rst_n = 1;
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (!cmd_ref && n < PAUSE) chk(!init_done, "R3", "init_done during pause", init_done, 0);
        end while (!cmd_ref && n < 3 * PAUSE);
        chk(n == PAUSE, "R2", "cycles to first wake refresh", n, PAUSE);
        wait_empty("R3", 200);
        chk(init_done == 1, "R3", "init_done after wake", init_done, 1);
        sb_on = 0;

        // R4: pacing in each option setting
        gap_check(0, 0, P2, "R4");
        gap_check(1, 0, P4, "R4");
        gap_check(0, 1, E2, "R4");
        gap_check(1, 1, E4, "R4");
        row_4k = 0;
        ext_period = 0;

        // R5: a pending refresh is served before a waiting host request
        wait_ref();
        @(negedge clk);
        force_busy = 1;
        host_req = 1;
        push(C_REF, 1);
        push(C_HOST, 1);
        sb_on = 1;
        repeat (P2 + 10) @(negedge clk);
        force_busy = 0;
        wait_empty("R5", 100);
        sb_on = 0;

        // R7: backlog overflow re-arms the wake-up sequence
        wait_ref();
        @(negedge clk);
        force_busy = 1;
        n = 0;
        while (!ovf_err && n < 15 * P2) begin
            @(negedge clk);
            n++;
        end
        chk(ovf_err == 1, "R7", "overflow flag", ovf_err, 1);
        chk(init_done == 0, "R7", "init_done after overflow", init_done, 0);
        push(C_REF, WAKE);
        sb_on = 1;
        force_busy = 0;
        n = 0;
        while (!init_done && n < 200) begin
            @(negedge clk);
            n++;
        end
        sb_on = 0;
        chk(exp_q.size() == 0, "R7", "wake refreshes left", exp_q.size(), 0);
        chk(ovf_err == 1, "R7", "flag sticky", ovf_err, 1);

        // R8/R9/R10: self refresh with distributed refresh, host waiting
        dist_mode = 1;
        wait_ref();
        @(negedge clk);
        push(C_SR, 1);
        push(C_HOST, 1);
        sb_on = 1;
        sr_req = 1;
        host_req = 1;
        while (!sr_hold) @(negedge clk);
        n = 0;
        while (sr_hold) begin
            n++;
            if (n == 5) sr_req = 0;
            @(negedge clk);
        end
        chk(n == RASS, "R8", "self-refresh hold length", n, RASS);
        n = 0;
        while (!cmd_host && n < 50) begin
            if (cmd_ref || cmd_sr) chk(0, "R9", "command in recovery", n, RPS);
            @(negedge clk);
            n++;
        end
        chk(n == RPS, "R9", "cycles from exit to host grant", n, RPS);
        @(negedge clk);
        sb_on = 0;
        chk(exp_q.size() == 0, "R10", "no catch-up with distributed", exp_q.size(), 0);

        // R10: catch-up burst for both row options
        dist_mode = 0;
        for (int r = 0; r < 2; r++) begin
            row_4k = r[0];
            wait_ref();
            @(negedge clk);
            push(C_SR, 1);
            push(C_REF, r ? ROWS4 : ROWS2);
            push(C_HOST, 1);
            sb_on = 1;
            sr_req = 1;
            host_req = 1;
            while (!sr_hold) @(negedge clk);
            sr_req = 0;
            wait_empty("R10", RASS + 8 * ROWS4);
            @(negedge clk);
            sb_on = 0;
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule